// File: doc/BRIEF.md
# Serial-Capture Branch Distance Unit

This block sits at the front of a hard-decision convolutional decoder for a rate 2/3 code. Coded bits arrive one per clock. Each bit is qualified by a valid strobe. The block gathers the bits of each codeword into a small collection register. On the cycle that completes a codeword, it copies the word into a held register. The distance logic is fed only from that held register.

From the held word, the block reports the Hamming distance to every possible branch label at once. Downstream add-compare-select logic consumes these distances. Between completions the held word does not move, so the distance logic does not toggle while the next codeword is being gathered. A one-cycle strobe marks each fresh set of distances.

Top module: `serial_branch_dist`

## Requirements
- R1: While `rst` is sampled high, the partial codeword, the bit position and the held word are cleared and `dist_valid` is low. Right after reset the held word is zero, so the distance to label N equals the number of ones in N.
- R2: A bit is taken only on a clock edge where `in_valid` is high. Edges with `in_valid` low neither advance the bit position nor change any output.
- R3: Within a codeword, the first accepted bit is the most significant bit of the held word and the last accepted bit is its least significant bit.
- R4: Field N of `dist_o` is the label distance for label N. Field N occupies bits `[N*DIST_W +: DIST_W]`. Its value is the count of bit positions where the held word and the binary value N differ. The range is 0 to SYM_BITS, which is 0 to 3 by default with DIST_W = 2.
- R5: `dist_o` changes only on the cycle after an edge that accepts the last bit of a codeword. At every other time it holds its value.
- R6: `dist_valid` is high for exactly one cycle: the cycle after the edge that accepts the last bit of a codeword. In that cycle `dist_o` already reflects the new word.
- R7: With `in_valid` held high, codewords complete back to back, and `dist_valid` pulses once every SYM_BITS cycles.
- R8: A reset in the middle of a codeword discards the bits gathered so far. The next accepted bit is treated as the first bit of a new codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_bit` on this edge |
| in_bit | input | 1 | Hard-decision coded bit |
| dist_valid | output | 1 | One-cycle strobe: new distances present |
| dist_o | output | NUM_LABELS*DIST_W (8*2) | Packed distances, field N for label N |

## Verification
The bench builds the block with its default SYM_BITS of 3. That gives eight labels and two-bit distances, so every codeword value, and therefore every distance value from 0 to 3 on every lane, can be reached exhaustively. Mixing gapless streams with sparse and randomly gated valid patterns covers both the back-to-back pulse spacing and the frozen-output periods. A mid-codeword reset covers the restart of the bit position.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
  localparam int MAX_SYM = 16;
  typedef logic [MAX_SYM-1:0] word_t;

  // Count positions where two words disagree.
  function automatic int unsigned bit_diff(word_t a, word_t b);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_SYM; i++) begin
      if (a[i] != b[i]) n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/bdu_collect.sv
module bdu_collect #(
  parameter int SYM_BITS = 3,
  localparam int CNT_W = $clog2(SYM_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic [SYM_BITS-1:0] word_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_BITS - 1);

  logic [SYM_BITS-2:0] part_q;
  logic [CNT_W-1:0]    idx_q;

  assign word_o = {part_q, in_bit};
  assign done_o = in_valid && (idx_q == LAST);
  assign idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      idx_q  <= '0;
    end else if (in_valid) begin
      part_q <= word_o[SYM_BITS-2:0];
      idx_q  <= done_o ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bdu_hold.sv
module bdu_hold #(
  parameter int SYM_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SYM_BITS-1:0] word_i,
  output logic [SYM_BITS-1:0] held_o,
  output logic                valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) held_o <= word_i;
    end
  end
endmodule

// File: rtl/bdu_lane.sv
module bdu_lane
  import bdu_pkg::*;
#(
  parameter int SYM_BITS = 3,
  parameter int LABEL    = 0,
  parameter int DIST_W   = 2
) (
  input  logic [SYM_BITS-1:0] word_i,
  output logic [DIST_W-1:0]   dist_o
);
  localparam word_t REF = word_t'(LABEL);
  assign dist_o = DIST_W'(bit_diff(word_t'(word_i), REF));
endmodule

// File: rtl/serial_branch_dist.sv
module serial_branch_dist #(
  parameter int SYM_BITS = 3,
  localparam int DIST_W     = $clog2(SYM_BITS + 1),
  localparam int NUM_LABELS = 1 << SYM_BITS,
  localparam int CNT_W      = $clog2(SYM_BITS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_bit,
  output logic                         dist_valid,
  output logic [NUM_LABELS*DIST_W-1:0] dist_o
);
  logic [SYM_BITS-1:0] gathered;
  logic [SYM_BITS-1:0] held_word;
  logic                load_evt;
  logic [CNT_W-1:0]    bit_idx;

  bdu_collect #(.SYM_BITS(SYM_BITS)) u_collect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .word_o(gathered), .done_o(load_evt), .idx_o(bit_idx)
  );

  bdu_hold #(.SYM_BITS(SYM_BITS)) u_hold (
    .clk(clk), .rst(rst), .load_i(load_evt), .word_i(gathered),
    .held_o(held_word), .valid_o(dist_valid)
  );

  for (genvar g = 0; g < NUM_LABELS; g++) begin : g_lane
    bdu_lane #(.SYM_BITS(SYM_BITS), .LABEL(g), .DIST_W(DIST_W)) u_lane (
      .word_i(held_word),
      .dist_o(dist_o[g*DIST_W +: DIST_W])
    );
  end
endmodule

// File: rtl/bdu_checker.sv
module bdu_checker #(
  parameter int SYM_BITS = 3,
  localparam int DIST_W     = $clog2(SYM_BITS + 1),
  localparam int NUM_LABELS = 1 << SYM_BITS,
  localparam int CNT_W      = $clog2(SYM_BITS)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         load_evt,
  input logic [CNT_W-1:0]             bit_idx,
  input logic                         dist_valid,
  input logic [NUM_LABELS*DIST_W-1:0] dist_o
);
  localparam int TOP_LO = (NUM_LABELS - 1) * DIST_W;

  // R1
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(bit_idx) < SYM_BITS);

  // R2
  idle_holds_idx_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(bit_idx));

  // R4
  complement_sum_chk: assert property (@(posedge clk) disable iff (rst)
    int'(dist_o[DIST_W-1:0]) + int'(dist_o[TOP_LO +: DIST_W]) == SYM_BITS);

  // R5
  frozen_dist_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(dist_o));

  // R6
  strobe_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> dist_valid);

  // R6
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> !dist_valid);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |=> !dist_valid);
endmodule

bind serial_branch_dist bdu_checker #(.SYM_BITS(SYM_BITS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .load_evt(load_evt),
  .bit_idx(bit_idx), .dist_valid(dist_valid), .dist_o(dist_o)
);

// File: tb/tb_serial_branch_dist.sv
`timescale 1ns/1ps
module tb_serial_branch_dist;
  localparam int N  = 3;
  localparam int DW = $clog2(N + 1);
  localparam int NL = 1 << N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic dist_valid;
  logic [NL*DW-1:0] dist_o;

  always #2.5 clk = ~clk;

  serial_branch_dist #(.SYM_BITS(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .dist_valid(dist_valid), .dist_o(dist_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int ref_cnt = 0;
  int ref_acc = 0;
  int ref_held = 0;
  bit ref_vld = 0;
  string tag = "R1";
  int lfsr = 32'h1ACE;

  function automatic int ones(int x);
    int c = 0;
    for (int i = 0; i < 32; i++) if (x[i]) c++;
    return c;
  endfunction

  task automatic compare();
    bit bad = 0;
    compared++;
    if (dist_valid !== ref_vld) begin
      mismatched++;
      $display("FAIL R6 dist_valid actual=%0b expected=%0b", dist_valid, ref_vld);
    end
    compared++;
    for (int l = 0; l < NL; l++) begin
      int exp_d = ones(ref_held ^ l);
      if (int'(dist_o[l*DW +: DW]) != exp_d) begin
        bad = 1;
        $display("FAIL %s hd%0d actual=%0d expected=%0d", tag, l,
                 dist_o[l*DW +: DW], exp_d);
      end
    end
    if (bad) mismatched++;
  endtask

  task automatic cyc(input bit r, input bit v, input bit b);
    @(negedge clk);
    rst = r; in_valid = v; in_bit = b;
    @(posedge clk);
    if (r) begin
      ref_cnt = 0; ref_acc = 0; ref_held = 0; ref_vld = 0;
    end else begin
      ref_vld = 0;
      if (v) begin
        ref_acc = ((ref_acc << 1) | int'(b)) & (NL - 1);
        if (ref_cnt == N - 1) begin
          ref_held = ref_acc; ref_vld = 1; ref_cnt = 0;
        end else ref_cnt++;
      end
    end
    #1;
    compare();
  endtask

  task automatic send_word(input int w, input int gap);
    for (int i = N - 1; i >= 0; i--) begin
      cyc(0, 1, w[i]);
      for (int g = 0; g < gap; g++) cyc(0, 0, ~w[i]);
    end
  endtask

  initial begin
    // R1: reset state, distance equals popcount of label
    tag = "R1";
    cyc(1, 0, 0); cyc(1, 1, 1); cyc(1, 0, 0);

    // R3: first bit lands in MSB, word 100 -> hd4 must be zero
    tag = "R3";
    send_word(4, 0);
    cyc(0, 0, 0);
    compared++;
    if (dist_o[4*DW +: DW] !== '0) begin
      mismatched++;
      $display("FAIL R3 hd4 actual=%0d expected=0", dist_o[4*DW +: DW]);
    end

    // R4 and R7: every word back to back, pulse each N cycles
    tag = "R7";
    for (int w = 0; w < NL; w++) send_word(w, 0);
    tag = "R4";
    for (int w = NL - 1; w >= 0; w--) send_word(w, 0);

    // R2 and R5: sparse valid, idle bits must not be taken
    tag = "R2";
    for (int w = 0; w < NL; w++) send_word(w ^ 5, 2);
    tag = "R5";
    for (int k = 0; k < 10; k++) cyc(0, 0, k[0]);

    // R8: reset after two bits, restart at index 0
    tag = "R8";
    cyc(0, 1, 1); cyc(0, 1, 1);
    cyc(1, 0, 0);
    send_word(3, 0);
    send_word(6, 1);

    // mixed random valid pattern
    tag = "R4";
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      cyc(0, lfsr[3] | lfsr[7], lfsr[0]);
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule